// File: doc/BRIEF.md
# Configurable Event Counter Slice

This block is one counting slot of a performance monitor. Each cycle it receives a flat vector of single-cycle event strobes, arranged as several groups of 32 events. A 64-bit configuration word picks one group and a 32-bit mask of events within it. The masked strobes that are set are summed. That sum is then qualified: it can be gated by a traffic filter, compared against a threshold, inverted, or reduced to rising edges. The result is added to a counter whose width is a parameter and which wraps modulo two to the power of that width.

The slot type is fixed when the block is built: free-running, fixed-function or configurable. On a configurable slot, software chooses the group and the mask. On the other two types those fields are constants that ignore writes, and a free-running slot always counts. A single write port reaches three targets: the configuration word, the counter value and the filter value. An external freeze input holds the counter, and the slot can also halt itself when the counter wraps. The counter value stays writable in every state.

The control is a three-state machine. In OFF the slot does not count. In RUN it counts. In HALT it has stopped itself after a wrap. The transitions are:
- `go`: OFF to RUN, when the enable bit is set.
- `stop`: RUN to OFF, when the enable bit is clear.
- `trip`: RUN to HALT, on a wrap with freeze-on-overflow set.
- `release`: HALT to OFF, on any configuration write.

The state register updates on the clock edge after the configuration register, so counting starts on the second clock edge after the write that enables it.

Top module: `perf_cnt_slice`

## Requirements
- R1: After reset the counter is 0, `ovf_o`, `ovf_int_o` and `frozen_o` are 0, and the filter value is 0xFFFF_FFFF. The configuration readback has these fields:
  - Bits [1:0] hold the slot type: 0 free-running, 1 fixed-function, 2 configurable.
  - Bits [7:2], [15:13] and [58:56] read as 0.
  - All writable fields reset to 0. The exception is the enable bit of a free-running slot, which always reads 1.
- R2: While counting with threshold 0 or 1, no inversion and level mode, each clock edge adds the number of set strobes in the selected group whose mask bit is set.
  - The mask is configuration bits [55:24]; mask bit i selects strobe i.
  - The group index is bits [63:59]; group g is `events_i[g*32 +: 32]`.
  - A group index of `GRP_N` or more selects no events.
- R3: Bit 8 enables counting. A configuration write that sets it starts counting on the second clock edge after the write. While the slot is disabled, strobes do not change the counter.
- R4: With threshold bits [23:16] at 2 or more and no inversion, each edge adds 1 if the qualified sum is at least the threshold, and 0 otherwise.
- R5: With bit 12 set, each edge adds 1 if the qualified sum is below the threshold, and 0 otherwise. A threshold of 0 is treated as 1.
- R6: With bit 11 set, each edge adds 1 only when the qualification condition (sum at least the threshold, or below it when inverted; threshold 0 treated as 1) is true in this cycle and was false in the previous cycle.
- R7: The filter value is written with selector 2. The value 0xFFFF_FFFF disables filtering. Any other value zeroes the sum in every cycle where `filt_tag_i` differs from it.
- R8: The counter wraps modulo 2^`CNT_W`. On the edge where an addition carries out of the top bit, `ovf_o` becomes 1 for exactly one cycle, in the same cycle as the wrapped value. `ovf_int_o` pulses along with it only if bit 9 is set.
- R9: With bit 10 set, a wrap moves the slot to HALT and sets `frozen_o`. In HALT the counter does not count. Any configuration write leaves HALT and clears `frozen_o` on the next edge.
- R10: While `freeze_i` is 1 the counter does not count. A counter write (selector 1) loads `wr_data_i[CNT_W-1:0]` on the next edge in every state, including frozen and halted. A counter write takes priority over counting.
- R11: On fixed-function and free-running slots, the mask and group fields read as the build-time constants `FIX_MASK` and `FIX_GRP`, and writes to them are ignored. A free-running slot counts regardless of bit 8. The enable, threshold, edge, invert and overflow bits stay writable on every type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| events_i | input | GRP_N*32 | Per-cycle event strobes, group g at bits [g*32 +: 32] |
| filt_tag_i | input | 32 | Tag of the current traffic, compared with the filter value |
| freeze_i | input | 1 | External freeze; holds the counter |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 configuration, 1 counter, 2 filter, 3 none |
| wr_data_i | input | 64 | Write data |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |
| ovf_int_o | output | 1 | Wrap pulse gated by the interrupt-request bit |
| frozen_o | output | 1 | Slot is halted after a wrap |
| cfg_o | output | 64 | Configuration readback |

## Verification
The counting tests drive two kinds of pattern:
- Full groups of strobes against a sparse mask, while a neighbouring group is busy. This shows whether the mask and the group selection both act.
- Sequences of sums that sit just above, at and just below a threshold. These separate the raw-sum, threshold, inverted and edge paths, because the same stimulus gives a different count in each mode.

The filter is tested with a matching tag and then a non-matching tag, and again after it is set back to all-ones. The wrap tests start a few counts below the top. One of them uses a sum of three, which carries past zero rather than landing on it; this exposes a wrap detector that looks only for all-ones.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int EV_W  = 32;
    localparam int SUM_W = $clog2(EV_W + 1);

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_FIXED = 2'd1,
        KIND_CONF  = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } st_e;

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_FILT = 2'd2;

    localparam int B_EN   = 8;
    localparam int B_IRQ  = 9;
    localparam int B_FRZ  = 10;
    localparam int B_EDGE = 11;
    localparam int B_INV  = 12;
    localparam int B_THR  = 16;
    localparam int B_MSK  = 24;
    localparam int B_GRP  = 59;
endpackage

// File: rtl/pcs_pick.sv
module pcs_pick #(
    parameter int GRP_N = 4,
    parameter int EV_W  = 32,
    parameter int SUM_W = 6
) (
    input  logic [GRP_N*EV_W-1:0] events_i,
    input  logic [4:0]            grp_i,
    input  logic [EV_W-1:0]       mask_i,
    output logic [SUM_W-1:0]      sum_o
);
    logic [EV_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int g = 0; g < GRP_N; g++) begin
            if (32'(grp_i) == g) sel = events_i[g*EV_W +: EV_W];
        end
    end

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < EV_W; i++) begin
            sum_o = sum_o + SUM_W'(sel[i] & mask_i[i]);
        end
    end
endmodule

// File: rtl/pcs_qual.sv
module pcs_qual #(
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [31:0]      filt_val_i,
    input  logic [31:0]      filt_tag_i,
    input  logic [7:0]       thr_i,
    input  logic             inv_i,
    input  logic             edge_i,
    output logic [SUM_W-1:0] inc_o
);
    logic       filt_ok;
    logic [7:0] g8;
    logic [7:0] thr_eff;
    logic       cond;
    logic       prev_q;

    always_comb begin
        filt_ok = (filt_val_i == 32'hFFFF_FFFF) || (filt_tag_i == filt_val_i);
        g8      = filt_ok ? {{(8-SUM_W){1'b0}}, sum_i} : 8'd0;
        thr_eff = (thr_i == 8'd0) ? 8'd1 : thr_i;
        cond    = inv_i ? (g8 < thr_eff) : (g8 >= thr_eff);
        if (edge_i)
            inc_o = SUM_W'(cond && !prev_q);
        else if (!inv_i && thr_i <= 8'd1)
            inc_o = g8[SUM_W-1:0];
        else
            inc_o = SUM_W'(cond);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cond;
    end
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice import pcs_pkg::*; #(
    parameter int          CNT_W    = 48,
    parameter int          GRP_N    = 4,
    parameter kind_e       KIND     = KIND_CONF,
    parameter logic [31:0] FIX_MASK = 32'h0000_00F0,
    parameter logic [4:0]  FIX_GRP  = 5'd1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GRP_N*EV_W-1:0] events_i,
    input  logic [31:0]           filt_tag_i,
    input  logic                  freeze_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_sel_i,
    input  logic [63:0]           wr_data_i,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  ovf_o,
    output logic                  ovf_int_o,
    output logic                  frozen_o,
    output logic [63:0]           cfg_o
);
    logic wr_cfg, wr_cnt, wr_filt;
    assign wr_cfg  = wr_en_i && (wr_sel_i == SEL_CFG);
    assign wr_cnt  = wr_en_i && (wr_sel_i == SEL_CNT);
    assign wr_filt = wr_en_i && (wr_sel_i == SEL_FILT);

    // writable on every kind
    logic       en_q, irq_q, frz_q, edge_q, inv_q;
    logic [7:0] thr_q;
    logic [31:0] filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; irq_q <= 1'b0; frz_q <= 1'b0;
            edge_q <= 1'b0; inv_q <= 1'b0; thr_q <= '0;
            filt_q <= 32'hFFFF_FFFF;
        end else begin
            if (wr_cfg) begin
                en_q   <= wr_data_i[B_EN];
                irq_q  <= wr_data_i[B_IRQ];
                frz_q  <= wr_data_i[B_FRZ];
                edge_q <= wr_data_i[B_EDGE];
                inv_q  <= wr_data_i[B_INV];
                thr_q  <= wr_data_i[B_THR +: 8];
            end
            if (wr_filt) filt_q <= wr_data_i[31:0];
        end
    end

    // kind-dependent fields
    logic [31:0] mask_v;
    logic [4:0]  grp_v;
    logic        en_v;

    generate
        if (KIND == KIND_CONF) begin : g_conf
            logic [31:0] mask_q;
            logic [4:0]  grp_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q <= '0;
                    grp_q  <= '0;
                end else if (wr_cfg) begin
                    mask_q <= wr_data_i[B_MSK +: 32];
                    grp_q  <= wr_data_i[B_GRP +: 5];
                end
            end
            assign mask_v = mask_q;
            assign grp_v  = grp_q;
        end else begin : g_const
            assign mask_v = FIX_MASK;
            assign grp_v  = FIX_GRP;
        end
        if (KIND == KIND_FREE) begin : g_always_on
            assign en_v = 1'b1;
        end else begin : g_sw_en
            assign en_v = en_q;
        end
    endgenerate

    assign cfg_o = {grp_v, 3'b000, mask_v, thr_q, 3'b000,
                    inv_q, edge_q, frz_q, irq_q, en_v, 6'b0, KIND};

    // event datapath
    logic [SUM_W-1:0] sum, inc;

    pcs_pick #(.GRP_N(GRP_N), .EV_W(EV_W), .SUM_W(SUM_W)) u_pick (
        .events_i (events_i),
        .grp_i    (grp_v),
        .mask_i   (mask_v),
        .sum_o    (sum)
    );

    pcs_qual #(.SUM_W(SUM_W)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .sum_i      (sum),
        .filt_val_i (filt_q),
        .filt_tag_i (filt_tag_i),
        .thr_i      (thr_q),
        .inv_i      (inv_q),
        .edge_i     (edge_q),
        .inc_o      (inc)
    );

    // state machine
    st_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   nxt;
    logic             count_go, wrap;

    always_comb begin
        count_go = (st_q == ST_RUN) && !freeze_i && !wr_cnt;
        nxt      = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        wrap     = count_go && nxt[CNT_W];
        frozen_o = (st_q == ST_HALT);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (en_v) st_d = ST_RUN;
            ST_RUN:  if (!en_v) st_d = ST_OFF;
                     else if (wrap && frz_q) st_d = ST_HALT;
            ST_HALT: if (wr_cfg) st_d = ST_OFF;
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_o     <= 1'b0;
            ovf_int_o <= 1'b0;
        end else begin
            if (wr_cnt)        cnt_q <= wr_data_i[CNT_W-1:0];
            else if (count_go) cnt_q <= nxt[CNT_W-1:0];
            ovf_o     <= wrap;
            ovf_int_o <= wrap && irq_q;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pcs_slice_chk.sv
module pcs_slice_chk #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [63:0]      wr_data_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             ovf_o,
    input logic             ovf_int_o,
    input logic             frozen_o
);
    logic cnt_wr;
    assign cnt_wr = wr_en_i && (wr_sel_i == 2'd1);

    assert_wrap_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (cnt_o < $past(cnt_o)));

    assert_int_with_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_int_o |-> ovf_o);

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !cnt_wr) |=> (cnt_o == $past(cnt_o)));

    assert_ext_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !cnt_wr) |=> (cnt_o == $past(cnt_o)));

    assert_cnt_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_o == $past(wr_data_i[CNT_W-1:0])));
endmodule

bind perf_cnt_slice pcs_slice_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze_i  (freeze_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_o),
    .ovf_o     (ovf_o),
    .ovf_int_o (ovf_int_o),
    .frozen_o  (frozen_o)
);

// File: tb/test_perf_cnt_slice.sv
`timescale 1ns/1ps
module test_perf_cnt_slice;
    localparam int CNT_W = 48;
    localparam int GRP_N = 4;
    localparam logic [CNT_W-1:0] TOP = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [GRP_N*32-1:0] events = '0;
    logic [31:0] tag = '0;
    logic freeze = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [63:0] wr_data = '0;

    logic [CNT_W-1:0] cnt, cnt_fx, cnt_fr;
    logic ovf, ovf_int, frozen, ovf_fx, oi_fx, fz_fx, ovf_fr, oi_fr, fz_fr;
    logic [63:0] cfg, cfg_fx, cfg_fr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    perf_cnt_slice #(.CNT_W(CNT_W), .GRP_N(GRP_N)) i_perf_cnt_slice (
        .clk(clk), .rst_n(rst_n), .events_i(events), .filt_tag_i(tag),
        .freeze_i(freeze), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .cnt_o(cnt), .ovf_o(ovf), .ovf_int_o(ovf_int), .frozen_o(frozen), .cfg_o(cfg));

    perf_cnt_slice #(.CNT_W(CNT_W), .GRP_N(GRP_N), .KIND(pcs_pkg::KIND_FIXED),
                     .FIX_MASK(32'h0000_00F0), .FIX_GRP(5'd1)) i_perf_cnt_slice_fix (
        .clk(clk), .rst_n(rst_n), .events_i(events), .filt_tag_i(tag),
        .freeze_i(freeze), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .cnt_o(cnt_fx), .ovf_o(ovf_fx), .ovf_int_o(oi_fx), .frozen_o(fz_fx), .cfg_o(cfg_fx));

    perf_cnt_slice #(.CNT_W(CNT_W), .GRP_N(GRP_N), .KIND(pcs_pkg::KIND_FREE),
                     .FIX_MASK(32'h0000_00F0), .FIX_GRP(5'd1)) i_perf_cnt_slice_free (
        .clk(clk), .rst_n(rst_n), .events_i(events), .filt_tag_i(tag),
        .freeze_i(freeze), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .cnt_o(cnt_fr), .ovf_o(ovf_fr), .ovf_int_o(oi_fr), .frozen_o(fz_fr), .cfg_o(cfg_fr));

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit en, input bit irq, input bit frz,
                                       input bit edg, input bit inv, input logic [7:0] thr,
                                       input logic [31:0] msk, input logic [4:0] grp);
        logic [63:0] v = '0;
        v[8] = en; v[9] = irq; v[10] = frz; v[11] = edg; v[12] = inv;
        v[23:16] = thr; v[55:24] = msk; v[63:59] = grp;
        return v;
    endfunction

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [GRP_N*32-1:0] ev, input int n);
        events = ev;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [GRP_N*32-1:0] g0(input logic [31:0] v);
        return {{(GRP_N-1)*32{1'b0}}, v};
    endfunction

    task automatic start(input logic [63:0] c);
        wr(2'd0, c);
        step('0, 2);
        wr(2'd1, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1", "cnt", 64'(cnt), 64'd0);
        chk("R1", "ovf", {62'd0, ovf, ovf_int}, 64'd0);
        chk("R1", "frozen", 64'(frozen), 64'd0);
        chk("R1", "cfg conf", cfg, 64'h2);
        chk("R1", "cfg fixed", cfg_fx, (64'd1 << 59) | (64'hF0 << 24) | 64'h1);
        chk("R1", "cfg free", cfg_fr, (64'd1 << 59) | (64'hF0 << 24) | (64'd1 << 8));
    endtask

    task automatic t_sum;
        step('1, 3); step('0, 1);
        chk("R3", "disabled ignores events", 64'(cnt), 64'd0);
        start(mk(1,0,0,0,0,8'd0,32'h0000_0F0F,5'd2));
        step({32'h0, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFFF}, 3); step('0, 1);
        chk("R2", "masked sum grp2", 64'(cnt), 64'd24);
        step({32'h0, 32'h0000_0101, 32'h0, 32'h0}, 2); step('0, 1);
        chk("R2", "sparse pattern", 64'(cnt), 64'd28);
        wr(2'd0, mk(1,0,0,0,0,8'd0,32'hFFFF_FFFF,5'd7));
        step('1, 3); step('0, 1);
        chk("R2", "group out of range", 64'(cnt), 64'd28);
        wr(2'd0, mk(0,0,0,0,0,8'd0,32'hFFFF_FFFF,5'd0));
        step('0, 2); step('1, 3); step('0, 1);
        chk("R3", "disable stops", 64'(cnt), 64'd28);
    endtask

    task automatic t_thr;
        start(mk(1,0,0,0,0,8'd3,32'hFFFF_FFFF,5'd0));
        step(g0(32'hF), 1); step(g0(32'h3), 1); step(g0(32'h7), 1);
        step(g0(32'h1F), 1); step(g0(32'h1), 1); step('0, 1);
        chk("R4", "threshold 3", 64'(cnt), 64'd3);
    endtask

    task automatic t_inv;
        wr(2'd0, mk(1,0,0,0,1,8'd4,32'hFFFF_FFFF,5'd0));
        step(g0(32'h1F), 1);
        wr(2'd1, 64'd0);
        step(g0(32'h1F), 2); step(g0(32'h3), 3); step(g0(32'h1F), 2);
        chk("R5", "below threshold", 64'(cnt), 64'd3);
        wr(2'd0, 64'd0); step(g0(32'h1F), 2);
    endtask

    task automatic t_edge;
        start(mk(1,0,0,1,0,8'd0,32'hFFFF_FFFF,5'd0));
        step(g0(32'h1), 3); step('0, 2); step(g0(32'h7), 3); step('0, 1);
        chk("R6", "rising edges", 64'(cnt), 64'd2);
    endtask

    task automatic t_filt;
        wr(2'd2, 64'h1234);
        start(mk(1,0,0,0,0,8'd0,32'hFFFF_FFFF,5'd0));
        tag = 32'h1234; step(g0(32'h7), 2);
        tag = 32'h5;    step(g0(32'h7), 3); step('0, 1);
        chk("R7", "filter match only", 64'(cnt), 64'd6);
        wr(2'd2, 64'hFFFF_FFFF);
        step(g0(32'h7), 1); step('0, 1);
        chk("R7", "all-ones disables", 64'(cnt), 64'd9);
        tag = 32'h0;
    endtask

    task automatic t_wrap;
        wr(2'd0, mk(1,1,0,0,0,8'd0,32'h7,5'd0));
        step('0, 2);
        wr(2'd1, 64'(TOP));
        step(g0(32'h7), 1);
        chk("R8", "wrapped value", 64'(cnt), 64'd2);
        chk("R8", "pulse", {62'd0, ovf, ovf_int}, 64'd3);
        step(g0(32'h7), 1);
        chk("R8", "continues", 64'(cnt), 64'd5);
        chk("R8", "pulse one cycle", 64'(ovf), 64'd0);
        step('0, 1);
    endtask

    task automatic t_selffrz;
        wr(2'd0, mk(1,0,1,0,0,8'd0,32'h1,5'd0));
        step('0, 2);
        wr(2'd1, 64'(TOP - 1));
        step(g0(32'h1), 2);
        chk("R9", "wrap to zero", 64'(cnt), 64'd0);
        chk("R9", "ovf no irq", {62'd0, ovf, ovf_int}, 64'd2);
        chk("R9", "halted", 64'(frozen), 64'd1);
        step(g0(32'h1), 3);
        chk("R9", "held", 64'(cnt), 64'd0);
        wr(2'd1, 64'd7);
        chk("R10", "write while halted", 64'(cnt), 64'd7);
        step('0, 1);
        wr(2'd0, mk(1,0,1,0,0,8'd0,32'h1,5'd0));
        chk("R9", "release", 64'(frozen), 64'd0);
        step('0, 2); step(g0(32'h1), 2); step('0, 1);
        chk("R9", "counts again", 64'(cnt), 64'd9);
    endtask

    task automatic t_extfrz;
        start(mk(1,0,0,0,0,8'd0,32'h1,5'd0));
        step(g0(32'h1), 2);
        freeze = 1'b1;
        step(g0(32'h1), 3);
        chk("R10", "freeze holds", 64'(cnt), 64'd2);
        wr(2'd1, 64'd100);
        chk("R10", "write while frozen", 64'(cnt), 64'd100);
        step(g0(32'h1), 1);
        chk("R10", "still held", 64'(cnt), 64'd100);
        freeze = 1'b0;
        step(g0(32'h1), 2); step('0, 1);
        chk("R10", "resumes", 64'(cnt), 64'd102);
    endtask

    task automatic t_fixed;
        wr(2'd0, mk(0,0,0,0,0,8'd0,32'hFFFF_FFFF,5'd0));
        chk("R11", "free enable reads 1", 64'(cfg_fr[8]), 64'd1);
        chk("R11", "fixed enable writable", 64'(cfg_fx[8]), 64'd0);
        start(mk(1,0,0,0,0,8'd0,32'hFFFF_FFFF,5'd0));
        chk("R11", "fixed fields ignore write", cfg_fx,
            (64'd1 << 59) | (64'hF0 << 24) | (64'd1 << 8) | 64'h1);
        chk("R11", "conf fields take write", cfg,
            (64'hFFFF_FFFF << 24) | (64'd1 << 8) | 64'h2);
        step({32'h0, 32'h0, 32'h0000_00FF, 32'h0}, 2); step('0, 1);
        chk("R11", "fixed counts its group", 64'(cnt_fx), 64'd8);
        chk("R11", "free counts", 64'(cnt_fr), 64'd8);
        chk("R2", "conf grp0 idle", 64'(cnt), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sum();
        t_thr();
        t_inv();
        t_edge();
        t_filt();
        t_wrap();
        t_selffrz();
        t_extfrz();
        t_fixed();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule